// File: doc/BRIEF.md
# Serial-Reset Power Mode Controller

This block holds the power state of a converter's digital core: active, standby or power-down. It drives the enables for the core regulator, the clock oscillator and the GPIO output drivers. It also drives a register-file clear. A register write of a two-bit mode field requests a state change. The clock-select field of the register file decides whether the oscillator keeps running in standby.

A synchronous serial bus (clock, active-low select, data in) is watched for a long run of ones. That run resets the serial interface in any state. It is also the only way out of power-down. The run is counted on serial clock rising edges that the block sees through an edge detector in the system clock domain.

After a wake-up the block stays busy for a programmable number of system clock cycles while the regulator settles. During that time serial commands and mode writes are dropped.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the state output is 00 (active), busy and sif_reset are low, and ldo_en, osc_en and gpio_oe are high while regs_clear is low.
- R2: In standby (state 01) ldo_en and gpio_oe stay high and regs_clear stays low. osc_en is high only when clk_sel is non-zero; clk_sel 00 selects the internal oscillator, which is gated off.
- R3: A mode write of 11 (power-down) takes effect only when the current state is standby. From active it leaves the state unchanged.
- R4: In power-down (state 10) ldo_en, osc_en and gpio_oe are low and regs_clear is high, whatever the value of clk_sel.
- R5: Power-down is left only after RESET_BITS (64) consecutive serial clock rising edges with cs_n low and sdi high. An edge with sdi low, or cs_n high at any time, restarts the count from zero.
- R6: On leaving power-down the state becomes active and busy is high for exactly SETTLE_CYCLES system cycles. While busy, cmd_accept stays low and mode writes are ignored.
- R7: A completed run of ones pulses sif_reset for one cycle. In active or standby it leaves the state unchanged.
- R8: In power-down, mode writes are ignored and cmd_accept stays low.
- R9: Mode codes are 00 active, 10 standby and 11 power-down. Code 01 is ignored. Outside busy and power-down, cmd_accept follows cmd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock, sampled by clk |
| cs_n | input | 1 | Serial chip select, active low |
| sdi | input | 1 | Serial data in |
| mode_wr | input | 1 | Mode field write strobe |
| mode_val | input | 2 | Requested mode code |
| clk_sel | input | 2 | Clock source select, 00 is the internal oscillator |
| cmd_valid | input | 1 | A serial command has been received |
| pwr_state | output | 2 | 00 active, 01 standby, 10 power-down |
| ldo_en | output | 1 | Core regulator enable |
| osc_en | output | 1 | Oscillator enable |
| gpio_oe | output | 1 | GPIO output enable (low gives high impedance) |
| regs_clear | output | 1 | Hold the register file at reset values |
| sif_reset | output | 1 | One-cycle serial interface reset pulse |
| busy | output | 1 | Settle interval running |
| cmd_accept | output | 1 | Received command is passed on |

## Verification
A ones counter that is wrong shows up at the ports as a wake-up from power-down that comes too early or never comes. The run lengths from 1 to 63 are swept, each followed by a break, so a count that is off by one shows on pwr_state at the first edge past the break. A settle counter that is wrong shows as a busy window of the wrong length. That length is measured cycle by cycle from the wake edge. A wrong state decode shows at once on the enables the next cycle, with every clk_sel value applied.

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl #(
  parameter int RESET_BITS    = 64,
  parameter int SETTLE_CYCLES = 25000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       sdi,
  input  logic       mode_wr,
  input  logic [1:0] mode_val,
  input  logic [1:0] clk_sel,
  input  logic       cmd_valid,
  output logic [1:0] pwr_state,
  output logic       ldo_en,
  output logic       osc_en,
  output logic       gpio_oe,
  output logic       regs_clear,
  output logic       sif_reset,
  output logic       busy,
  output logic       cmd_accept
);
  localparam int CW = $clog2(RESET_BITS + 1);
  localparam int SW = $clog2(SETTLE_CYCLES + 2);
  localparam logic [1:0] ST_ACT = 2'b00, ST_STBY = 2'b01, ST_PD = 2'b10;
  localparam logic [1:0] M_ACT = 2'b00, M_STBY = 2'b10, M_PD = 2'b11;

  logic [1:0]    state;
  logic          sclk_q;
  logic [CW-1:0] ones_cnt;
  logic [SW-1:0] settle;

  wire rise     = sclk & ~sclk_q;
  wire run_done = rise & ~cs_n & sdi & (ones_cnt == CW'(RESET_BITS - 1));
  wire wake     = run_done & (state == ST_PD);
  wire cmd_ok   = ~busy & (state != ST_PD);

  assign busy       = (settle != '0);
  assign cmd_accept = cmd_valid & cmd_ok;
  assign pwr_state  = state;
  assign ldo_en     = (state != ST_PD);
  assign gpio_oe    = (state != ST_PD);
  assign regs_clear = (state == ST_PD);
  assign osc_en     = (state == ST_ACT) | ((state == ST_STBY) & (clk_sel != 2'b00));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      ones_cnt  <= '0;
      sif_reset <= 1'b0;
    end else begin
      sclk_q    <= sclk;
      sif_reset <= run_done;
      if (cs_n || (rise && (!sdi || run_done))) ones_cnt <= '0;
      else if (rise)                            ones_cnt <= ones_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_ACT;
      settle <= '0;
    end else begin
      if (wake)      settle <= SW'(SETTLE_CYCLES);
      else if (busy) settle <= settle - 1'b1;
      if (wake) state <= ST_ACT;
      else if (mode_wr && cmd_ok) begin
        case (mode_val)
          M_ACT:   state <= ST_ACT;
          M_STBY:  state <= ST_STBY;
          M_PD:    if (state == ST_STBY) state <= ST_PD;
          default: state <= state;
        endcase
      end
    end
  end

  assert_pd_from_standby_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PD && $past(state) != ST_PD) |-> $past(state) == ST_STBY);
  assert_pd_outputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PD) |-> (!ldo_en && !osc_en && !gpio_oe && regs_clear));
  assert_standby_keeps_ldo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STBY) |-> (ldo_en && gpio_oe && !regs_clear));
  assert_exit_by_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_PD && state != ST_PD) |-> (sif_reset && state == ST_ACT && busy));
  assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!cmd_accept && $stable(state) || $past(wake)));
  assert_pd_no_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PD) |-> !cmd_accept);
endmodule

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;
  localparam int S = 12;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, sdi = 0, mode_wr = 0, cmd_valid = 0;
  logic [1:0] mode_val = 0, clk_sel = 0;
  logic [1:0] pwr_state;
  logic ldo_en, osc_en, gpio_oe, regs_clear, sif_reset, busy, cmd_accept;
  int checks = 0, errors = 0, pulses = 0;

  pwr_mode_ctrl #(.RESET_BITS(64), .SETTLE_CYCLES(S)) dut_i (.*);

  always #10 clk = ~clk;
  always @(negedge clk) if (sif_reset) pulses++;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdi = b; cs_n = 0; sclk = 0;
    @(negedge clk); @(negedge clk);
    sclk = 1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic write_mode(input logic [1:0] m);
    mode_val = m; mode_wr = 1;
    @(negedge clk);
    mode_wr = 0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p0, nb;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 state", pwr_state, 0);
    check("R1 enables", {ldo_en, osc_en, gpio_oe, regs_clear}, 4'b1110);
    check("R1 busy/sif", {busy, sif_reset}, 0);
    for (int c = 0; c < 4; c++) begin
      clk_sel = c[1:0]; @(negedge clk);
      check("R1 active osc", osc_en, 1);
    end
    cmd_valid = 1; @(negedge clk);
    check("R9 accept follows valid", cmd_accept, 1);
    cmd_valid = 0; @(negedge clk);
    check("R9 accept low", cmd_accept, 0);
    write_mode(2'b11);
    check("R3 pd from active ignored", pwr_state, 0);
    write_mode(2'b01);
    check("R9 code 01 ignored", pwr_state, 0);
    write_mode(2'b10);
    check("R9 standby entered", pwr_state, 1);
    for (int c = 0; c < 4; c++) begin
      clk_sel = c[1:0]; @(negedge clk);
      check("R2 standby osc", osc_en, (c != 0) ? 1 : 0);
      check("R2 standby ldo/oe/clear", {ldo_en, gpio_oe, regs_clear}, 3'b110);
    end
    p0 = pulses;
    send_ones(64); cs_n = 1; @(negedge clk);
    check("R7 standby pulse", pulses - p0, 1);
    check("R7 standby kept", pwr_state, 1);
    write_mode(2'b11);
    check("R3 pd from standby", pwr_state, 2);
    for (int c = 0; c < 4; c++) begin
      clk_sel = c[1:0]; @(negedge clk);
      check("R4 pd outputs", {ldo_en, osc_en, gpio_oe, regs_clear}, 4'b0001);
    end
    write_mode(2'b00);
    check("R8 write in pd ignored", pwr_state, 2);
    cmd_valid = 1; @(negedge clk);
    check("R8 no accept in pd", cmd_accept, 0);
    cmd_valid = 0;
    for (int n = 1; n < 64; n++) begin
      send_ones(n); send_bit(1'b0);
      check("R5 short run stays pd", pwr_state, 2);
    end
    send_ones(40); cs_n = 1; @(negedge clk); @(negedge clk);
    send_ones(40); send_bit(1'b0);
    check("R5 cs break restarts", pwr_state, 2);
    for (int i = 0; i < 70; i++) begin
      sdi = 1; cs_n = 1; sclk = 0; @(negedge clk); sclk = 1; @(negedge clk);
    end
    check("R5 edges with cs high ignored", pwr_state, 2);
    p0 = pulses;
    send_ones(63);
    sdi = 1; cs_n = 0; sclk = 0; @(negedge clk); @(negedge clk);
    cmd_valid = 1; mode_wr = 1; mode_val = 2'b10;
    sclk = 1; @(negedge clk);
    check("R6 wake to active", pwr_state, 0);
    check("R6 enables after wake", {ldo_en, gpio_oe, regs_clear}, 3'b110);
    check("R7 wake pulse", sif_reset, 1);
    nb = 0;
    while (busy && nb < 1000) begin
      if (cmd_accept) begin
        check("R6 accept while busy", cmd_accept, 0);
      end
      nb++; @(negedge clk);
    end
    mode_wr = 0; cs_n = 1;
    check("R6 busy length", nb, S);
    check("R6 write during busy dropped", pwr_state, 0);
    check("R6 accept after settle", cmd_accept, 1);
    cmd_valid = 0;
    @(negedge clk);
    p0 = pulses;
    send_ones(64); cs_n = 1; @(negedge clk);
    check("R7 active pulse", pulses - p0, 1);
    check("R7 active kept", pwr_state, 0);
    check("R7 no busy in active", busy, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule